// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

The loader brings up a chip's registers from the contents of a serial EEPROM. It sits behind a byte-read engine that owns the serial bus. After a start pulse it asks that engine for one byte at a time, beginning at EEPROM address zero and climbing by one. It cuts the returned bytes into six-byte write records and presents each record as a full 32-bit register write on a valid/ready port.

A record holds a 14-bit double-word index and a 2-bit kind code in its first two bytes, followed by four data bytes with the least significant byte first. An end record is two bytes long and is followed by one checksum byte. The loader ends in one of three ways:

- when it has consumed that checksum byte;
- when it meets an unsupported kind code;
- when it has consumed the byte at the highest EEPROM address.

An erased device is recognised from the byte at address 1 and is left alone. On every ending the loader gives a one-cycle done pulse and holds its status flags until the next start.

Top module: `cfg_loader`

## Requirements
- R1: A start pulse while idle begins a load at EEPROM address 0. Each request asks for one byte, addresses rise by exactly one, and a new request is issued only after the previous byte has returned.
- R2: A record is decoded as follows. Byte 0 gives index bits [7:0]. Byte 1 bits [5:0] give index bits [13:8], and byte 1 bits [7:6] give the kind. Kind 0 is a write record of six bytes. Its bytes 2, 3, 4 and 5 give data bits [7:0], [15:8], [23:16] and [31:24].
- R3: Each write record produces exactly one write, in record order. `wr_addr` is the 14-bit index followed by two zero bits, `wr_data` is the full 32-bit word, and `wr_be` is 4'b1111.
- R4: While `wr_valid` is high and `wr_ready` is low, the write address and data hold steady and no read request is issued. Parsing resumes only after the write has been accepted.
- R5: If the byte at address 1 equals 0xFF, the load stops after that byte. In that case no write is issued, `blank` is set, and `csum_err` and `type_err` stay clear.
- R6: Kind 3 marks an end record. The byte that follows it is the checksum byte, and the load stops after that byte with no further request.
- R7: `csum_err` is set when the checksum byte differs from the modulo-256 sum of every byte read before it in this load.
- R8: Kind 1 or 2 sets `type_err` and stops the load after byte 1 of that record, with no write for it.
- R9: After the byte at the highest address (0xFFFF at the default width) has been consumed, the load stops. A record left incomplete at that point is discarded, and no status flag is set.
- R10: `done` is high for exactly one cycle at every ending, after which `busy` is low. The flags hold until the next accepted start, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load (taken only while idle) |
| rd_req | output | 1 | One-cycle request for the byte at `rd_addr` |
| rd_addr | output | 16 | EEPROM byte address of the request |
| rd_rsp_valid | input | 1 | Returned byte is present |
| rd_rsp_data | input | 8 | Returned byte |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 16 | Register byte address |
| wr_data | output | 32 | Register write data |
| wr_be | output | 4 | Byte enables, always all set |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| blank | output | 1 | Erased device detected |
| type_err | output | 1 | Unsupported record kind met |
| csum_err | output | 1 | Checksum mismatch at the end record |

## Verification
A wrong byte counter inside a record shows up as writes with a shuffled address or data. It can also show as a kind code read from the wrong byte, which ends the load early with `type_err`. Either is visible at the first write, or within six bytes. A stale or corrupted running sum only becomes visible as a wrong `csum_err` at the end of the load, so the bench varies record counts and deliberately corrupts checksums. Errors in the address counter show at once as a non-sequential `rd_addr` or a read count that differs from the image length. A mis-timed stop at the wrap boundary shows as an extra or a missing write.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the EEPROM configuration loader.
package cfg_loader_pkg;
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_BYTE,
        PS_CSUM,
        PS_WRITE,
        PS_FINISH
    } pstate_t;

    typedef enum logic [1:0] {
        REC_WRITE = 2'd0,
        REC_RSV1  = 2'd1,
        REC_RSV2  = 2'd2,
        REC_END   = 2'd3
    } rec_kind_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/cfg_loader_fetch.sv
// Byte fetcher: owns the EEPROM address counter and keeps at most one
// read outstanding. It assumes the read engine answers every request
// exactly once; a response that arrives with nothing outstanding is dropped.
module cfg_loader_fetch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              want,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [7:0]        rd_rsp_data,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    output logic              byte_last
);
    logic [ADDR_W-1:0] addr_q;
    logic              pend_q;

    // Track the outstanding request and advance the address when its byte returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= 1'b0;
        end else if (clear) begin
            addr_q <= '0;
            pend_q <= 1'b0;
        end else if (!pend_q && want) begin
            pend_q <= 1'b1;
        end else if (pend_q && rd_rsp_valid) begin
            pend_q <= 1'b0;
            addr_q <= addr_q + 1'b1;
        end
    end

    assign rd_req     = !pend_q && want && !clear;
    assign rd_addr    = addr_q;
    assign byte_valid = pend_q && rd_rsp_valid;
    assign byte_data  = rd_rsp_data;
    assign byte_last  = (addr_q == '1);
endmodule

// File: rtl/cfg_loader_sum.sv
// Running modulo-2^W sum of the accepted bytes. It is cleared when a load starts.
module cfg_loader_sum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] value,
    output logic [W-1:0] sum
);
    // Accumulate each accepted byte, wrapping at the width.
    always_ff @(posedge clk) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (add) sum <= sum + value;
    end
endmodule

// File: rtl/cfg_loader_parse.sv
// Record parser: splits the byte stream into write records and an end record,
// performs the erased-device check on byte 1 of the first record, and issues
// register writes with a valid/ready handshake. It assumes byte_valid arrives
// only while it asks for data (want high).
module cfg_loader_parse
    import cfg_loader_pkg::*;
#(
    parameter int WORD_W = 14,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  want,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    input  logic                  byte_last,
    output logic                  sum_clr,
    output logic                  sum_add,
    input  logic [7:0]            sum_val,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [WORD_W-1:0]     wr_word,
    output logic [DATA_W-1:0]     wr_data,
    output logic                  busy,
    output logic                  done,
    output logic                  blank,
    output logic                  type_err,
    output logic                  csum_err
);
    localparam int REC_LEN = 2 + DATA_W / 8;
    localparam int IDX_W   = $clog2(REC_LEN);
    localparam int HI_W    = WORD_W - 8;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_LEN - 1);

    pstate_t           state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              first_q;
    logic              wrap_q;
    logic [WORD_W-1:0] word_q;
    logic [DATA_W-1:0] data_q;
    rec_kind_t         kind;

    assign kind     = rec_kind_t'(byte_data[7:6]);
    assign want     = (state_q == PS_BYTE) || (state_q == PS_CSUM);
    assign sum_clr  = start && (state_q == PS_IDLE);
    assign sum_add  = (state_q == PS_BYTE) && byte_valid;
    assign wr_valid = (state_q == PS_WRITE);
    assign wr_word  = word_q;
    assign wr_data  = data_q;
    assign busy     = (state_q != PS_IDLE);
    assign done     = (state_q == PS_FINISH);

    // Walk the record bytes, record the status flags, and sequence writes and termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            idx_q    <= '0;
            first_q  <= 1'b0;
            wrap_q   <= 1'b0;
            word_q   <= '0;
            data_q   <= '0;
            blank    <= 1'b0;
            type_err <= 1'b0;
            csum_err <= 1'b0;
        end else begin
            case (state_q)
                PS_IDLE: if (start) begin
                    state_q  <= PS_BYTE;
                    idx_q    <= '0;
                    first_q  <= 1'b1;
                    wrap_q   <= 1'b0;
                    blank    <= 1'b0;
                    type_err <= 1'b0;
                    csum_err <= 1'b0;
                end
                PS_BYTE: if (byte_valid) begin
                    idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
                    if (idx_q == '0) begin
                        word_q[7:0] <= byte_data;
                        if (byte_last) state_q <= PS_FINISH;
                    end else if (idx_q == IDX_W'(1)) begin
                        word_q[WORD_W-1:8] <= byte_data[HI_W-1:0];
                        first_q <= 1'b0;
                        if (first_q && byte_data == ERASED_BYTE) begin
                            blank   <= 1'b1;
                            state_q <= PS_FINISH;
                        end else begin
                            case (kind)
                                REC_WRITE: if (byte_last) state_q <= PS_FINISH;
                                REC_END:   state_q <= byte_last ? PS_FINISH : PS_CSUM;
                                default: begin
                                    type_err <= 1'b1;
                                    state_q  <= PS_FINISH;
                                end
                            endcase
                        end
                    end else begin
                        data_q <= {byte_data, data_q[DATA_W-1:8]};
                        if (idx_q == IDX_LAST) begin
                            state_q <= PS_WRITE;
                            wrap_q  <= byte_last;
                        end else if (byte_last) begin
                            state_q <= PS_FINISH;
                        end
                    end
                end
                PS_CSUM: if (byte_valid) begin
                    csum_err <= (byte_data != sum_val);
                    state_q  <= PS_FINISH;
                end
                PS_WRITE: if (wr_ready) begin
                    state_q <= wrap_q ? PS_FINISH : PS_BYTE;
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_loader.sv
// Serial EEPROM configuration loader top. It couples the byte fetcher, the
// running sum and the record parser, and drives full-word register writes
// whose byte address is the record's double-word index shifted left.
module cfg_loader #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 14,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         rd_req,
    output logic [ADDR_W-1:0]            rd_addr,
    input  logic                         rd_rsp_valid,
    input  logic [7:0]                   rd_rsp_data,
    output logic                         wr_valid,
    input  logic                         wr_ready,
    output logic [WORD_W+$clog2(DATA_W/8)-1:0] wr_addr,
    output logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W/8-1:0]          wr_be,
    output logic                         busy,
    output logic                         done,
    output logic                         blank,
    output logic                         type_err,
    output logic                         csum_err
);
    localparam int LOW_W = $clog2(DATA_W / 8);

    logic              want, byte_valid, byte_last, sum_clr, sum_add;
    logic [7:0]        byte_data, sum_val;
    logic [WORD_W-1:0] wr_word;

    cfg_loader_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .clear(sum_clr), .want(want),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last)
    );

    cfg_loader_sum #(.W(8)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(sum_add),
        .value(byte_data), .sum(sum_val)
    );

    cfg_loader_parse #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .start(start), .want(want),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
        .sum_clr(sum_clr), .sum_add(sum_add), .sum_val(sum_val),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_word(wr_word), .wr_data(wr_data),
        .busy(busy), .done(done), .blank(blank), .type_err(type_err), .csum_err(csum_err)
    );

    assign wr_addr = {wr_word, {LOW_W{1'b0}}};
    assign wr_be   = '1;
endmodule

// File: rtl/cfg_loader_chk.sv
// Protocol checker for cfg_loader, attached through bind. It observes ports only.
module cfg_loader_chk #(
    parameter int ADDR_W = 16,
    parameter int AW     = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [AW-1:0]     wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              done,
    input logic              blank,
    input logic              type_err,
    input logic              csum_err
);
    // R1: an accepted start leads straight to a request for address zero.
    assert_first_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (rd_req && rd_addr == '0));

    // R1: never two requests back to back (one outstanding at most).
    assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R4: an offered write holds until taken.
    assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R4: no read while a write waits.
    assert_no_read_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !rd_req);

    // R5: an erased device gives no write and no checksum or kind error.
    assert_blank_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (!wr_valid && !csum_err && !type_err));

    // R10: done is a single-cycle pulse that leaves the loader idle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind cfg_loader cfg_loader_chk #(
    .ADDR_W(ADDR_W),
    .AW(WORD_W + $clog2(DATA_W / 8)),
    .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .blank(blank), .type_err(type_err), .csum_err(csum_err)
);

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0;

    // ---------------- main instance (16-bit addresses) ----------------
    logic        start = 1'b0;
    logic        rd_req, rsp_valid = 1'b0;
    logic [15:0] rd_addr;
    logic [7:0]  rsp_data = 8'h00;
    logic        wr_valid, wr_ready = 1'b0;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        busy, done, blank, type_err, csum_err;

    cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rsp_valid(rsp_valid), .rd_rsp_data(rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .busy(busy), .done(done), .blank(blank),
        .type_err(type_err), .csum_err(csum_err)
    );

    // ---------------- small instance for the wrap case ----------------
    logic        s_start = 1'b0, s_rsp_valid = 1'b0;
    logic        s_rd_req;
    logic [7:0]  s_rd_addr, s_rsp_data = 8'h00;
    logic        s_wr_valid;
    logic [15:0] s_wr_addr;
    logic [31:0] s_wr_data;
    logic [3:0]  s_wr_be;
    logic        s_busy, s_done, s_blank, s_type_err, s_csum_err;

    cfg_loader #(.ADDR_W(8)) uut_wrap (
        .clk(clk), .rst_n(rst_n), .start(s_start), .rd_req(s_rd_req), .rd_addr(s_rd_addr),
        .rd_rsp_valid(s_rsp_valid), .rd_rsp_data(s_rsp_data),
        .wr_valid(s_wr_valid), .wr_ready(1'b1), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
        .wr_be(s_wr_be), .busy(s_busy), .done(s_done), .blank(s_blank),
        .type_err(s_type_err), .csum_err(s_csum_err)
    );

    // ---------------- EEPROM image and expected writes ----------------
    logic [7:0]  mem [0:1023];
    logic [15:0] exp_wa [0:63];
    logic [31:0] exp_wd [0:63];
    int exp_n, got_n, rd_cnt, seq_err, pos;
    logic [15:0] next_addr;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        mem[pos] = b;
        pos++;
    endtask

    function automatic logic [7:0] sum_upto(input int n);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < n; i++) s = s + mem[i];
        return s;
    endfunction

    // R2/R3 model: a write record and the register write it must produce.
    task automatic put_write(input logic [13:0] word, input logic [31:0] data);
        put(word[7:0]);
        put({2'b00, word[13:8]});
        put(data[7:0]); put(data[15:8]); put(data[23:16]); put(data[31:24]);
        exp_wa[exp_n] = {word, 2'b00};
        exp_wd[exp_n] = data;
        exp_n++;
    endtask

    // R6/R7 model: end record plus checksum byte, optionally corrupted.
    task automatic put_end(input bit bad);
        logic [7:0] c;
        put(8'($urandom));
        put(8'hC0 | 8'($urandom % 64));
        c = sum_upto(pos);
        if (bad) c = c + 8'(1 + $urandom % 255);
        put(c);
    endtask

    // Byte-read engine model with random latency; also checks address order (R1).
    int unsigned dly = 0;
    bit          pend = 1'b0;
    logic [15:0] raddr;
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                rsp_valid = 1'b1;
                rsp_data  = mem[raddr[9:0]];
                pend      = 1'b0;
            end else dly = dly - 1;
        end
        if (rd_req) begin
            if (rd_addr != next_addr) seq_err++;
            next_addr = next_addr + 16'd1;
            rd_cnt++;
            pend  = 1'b1;
            raddr = rd_addr;
            dly   = $urandom % 3;
        end
        wr_ready = ($urandom % 2) == 0;
        if (wr_valid && wr_ready) begin
            if (got_n < exp_n) begin
                chk(wr_addr == exp_wa[got_n], "R3 write address", wr_addr, exp_wa[got_n]);
                chk(wr_data == exp_wd[got_n], "R2 write data", wr_data, exp_wd[got_n]);
                chk(wr_be == 4'hF, "R3 byte enables", wr_be, 4'hF);
            end else begin
                chk(1'b0, "R3 unexpected write", got_n, exp_n);
            end
            got_n++;
        end
    end

    // Responder and write sink for the wrap instance.
    bit          s_pend = 1'b0;
    logic [7:0]  s_raddr;
    int          s_rd_cnt = 0, s_wr_n = 0;
    logic [15:0] s_last_a = '0;
    logic [31:0] s_last_d = '0;
    always @(negedge clk) begin
        s_rsp_valid = 1'b0;
        if (s_pend) begin
            s_rsp_valid = 1'b1;
            s_rsp_data  = mem[{2'b00, s_raddr}];
            s_pend      = 1'b0;
        end
        if (s_rd_req) begin
            s_rd_cnt++;
            s_pend  = 1'b1;
            s_raddr = s_rd_addr;
        end
        if (s_wr_valid) begin
            s_wr_n++;
            s_last_a = s_wr_addr;
            s_last_d = s_wr_data;
        end
    end

    // One load on the main instance, then port-level checks of the outcome.
    task automatic run_load(input int exp_reads, input bit eb, input bit et, input bit ec,
                            input bit restart, input string tag);
        bit seen = 1'b0;
        int cnt_at_done;
        got_n = 0; rd_cnt = 0; seq_err = 0; next_addr = 16'd0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (restart && i == 7) start = 1'b1;
            if (restart && i == 8) start = 1'b0;
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(seen, {tag, " R10 done pulse seen"}, seen, 1);
        chk(blank == eb, {tag, " R5 blank flag"}, blank, eb);
        chk(type_err == et, {tag, " R8 kind error flag"}, type_err, et);
        chk(csum_err == ec, {tag, " R7 checksum flag"}, csum_err, ec);
        cnt_at_done = rd_cnt;
        @(negedge clk);
        chk(!done && !busy, {tag, " R10 single pulse then idle"}, {done, busy}, 0);
        repeat (5) @(negedge clk);
        chk(rd_cnt == exp_reads && cnt_at_done == exp_reads, {tag, " R1/R6 byte reads"}, rd_cnt, exp_reads);
        chk(seq_err == 0, {tag, " R1 sequential addresses"}, seq_err, 0);
        chk(got_n == exp_n, {tag, " R3 write count"}, got_n, exp_n);
        chk(blank == eb && type_err == et && csum_err == ec, {tag, " R10 flags held"},
            {blank, type_err, csum_err}, {eb, et, ec});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n, k;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_req && !wr_valid, "R10 reset idle", {busy, done, rd_req, wr_valid}, 0);
        chk(!blank && !type_err && !csum_err, "R10 reset flags", {blank, type_err, csum_err}, 0);

        // Directed: boundary index and data ordering (R2, R3), good checksum.
        pos = 0; exp_n = 0;
        put_write(14'h3FFF, 32'hDEADBEEF);
        put_write(14'h0001, 32'h04030201);
        put_end(1'b0);
        run_load(15, 0, 0, 0, 0, "directed-index");

        // Directed: end record first, no writes (R6).
        pos = 0; exp_n = 0;
        put(8'h12); put(8'hC0); put(8'h12 + 8'hC0);
        run_load(3, 0, 0, 0, 0, "end-first");

        // Directed: erased device (R5), even with valid-looking data after it.
        pos = 0; exp_n = 0;
        put(8'h00); put(8'hFF); put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        run_load(2, 1, 0, 0, 0, "erased");

        // Directed: start while busy is ignored (R10).
        pos = 0; exp_n = 0;
        for (int r = 0; r < 5; r++) put_write(14'(r * 97 + 5), $urandom);
        put_end(1'b0);
        run_load(33, 0, 0, 0, 1, "restart-ignored");

        // Random images: good checksum, corrupted checksum, unsupported kind.
        for (int t = 0; t < 9; t++) begin
            pos = 0; exp_n = 0;
            n = 1 + $urandom % 8;
            case (t % 3)
                0: begin
                    for (int r = 0; r < n; r++) put_write(14'($urandom), $urandom);
                    put_end(1'b0);
                    run_load(6 * n + 3, 0, 0, 0, 0, "random-good R7");
                end
                1: begin
                    for (int r = 0; r < n; r++) put_write(14'($urandom), $urandom);
                    put_end(1'b1);
                    run_load(6 * n + 3, 0, 0, 1, 0, "random-badsum R7");
                end
                default: begin
                    k = $urandom % n;
                    for (int r = 0; r < k; r++) put_write(14'($urandom), $urandom);
                    put(8'($urandom));
                    put(8'((1 + $urandom % 2) << 6) | 8'($urandom % 64));
                    put(8'h00); put(8'h00); put(8'h00); put(8'h00);
                    run_load(6 * k + 2, 0, 1, 0, 0, "random-kind R8");
                end
            endcase
        end

        // Wrap on the 8-bit-address instance (R9): 42 records fill 252 bytes, 4 left over.
        pos = 0; exp_n = 0;
        for (int r = 0; r < 42; r++) put_write(14'(r * 3 + 1), 32'h1000_0000 + r * 32'h0101_0101);
        put(8'h55); put(8'h00); put(8'h77); put(8'h88);
        @(negedge clk); s_start = 1'b1;
        @(negedge clk); s_start = 1'b0;
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 5000; i++) begin
                if (s_done) begin seen = 1'b1; break; end
                @(negedge clk);
            end
            chk(seen, "R9 wrap done pulse", seen, 1);
            chk(!s_blank && !s_type_err && !s_csum_err, "R9 wrap flags clear",
                {s_blank, s_type_err, s_csum_err}, 0);
        end
        repeat (5) @(negedge clk);
        chk(s_rd_cnt == 256, "R9 wrap read count", s_rd_cnt, 256);
        chk(s_wr_n == 42, "R9 partial record discarded", s_wr_n, 42);
        chk(s_last_a == {14'(41 * 3 + 1), 2'b00}, "R9 last write address", s_last_a, {14'(124), 2'b00});
        chk(s_last_d == 32'h1000_0000 + 41 * 32'h0101_0101, "R9 last write data",
            s_last_d, 32'h1000_0000 + 41 * 32'h0101_0101);
        chk(!s_busy, "R10 wrap idle", s_busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule